// File: doc/BRIEF.md
# Double-Buffered Converter Input Front End

This block is the digital front end of a 14-bit voltage-output converter. It holds two 14-bit registers in series. A staging register receives new codes. An output register drives the converter code. Only the output register reaches the converter, so a new code can be written ahead of time and applied later, at a chosen moment.

The staging register loads from one of two sources, chosen by a static mode pin. The first source is a 14-bit parallel bus, gated by two active-low strobes, select and write. The second is a serial frame of 16 bits on a serial clock, a frame-sync pin and a data pin. An active-low transfer strobe opens the output register. When the transfer strobe is held low, the output follows each write as soon as that write ends.

Every control and data pin passes through a two-flop synchronizer. Latch transparency is modelled by loading a register on each system clock cycle while its open condition holds.

A latch-control machine makes sure the two registers are never open in the same cycle. It has three states:
- LC_IDLE: both registers hold.
- LC_IN_OPEN: the staging register follows its source.
- LC_DAC_OPEN: the output register follows the staging register.

A write request moves the machine from any state to LC_IN_OPEN. A write request has priority, so it also takes LC_DAC_OPEN to LC_IN_OPEN. When no write request is present, a low transfer strobe leads to LC_DAC_OPEN. When neither is present, the machine goes to LC_IDLE.

A serial receiver machine also has three states:
- SR_IDLE: the bit count is cleared.
- SR_SHIFT: frame sync is low, and each rising serial clock shifts in one bit.
- SR_COMMIT: a one-cycle write request.

The receiver moves from SR_IDLE to SR_SHIFT when frame sync is low. When frame sync rises, it goes from SR_SHIFT to SR_COMMIT if exactly 16 bits arrived, and otherwise back to SR_IDLE. SR_COMMIT always returns to SR_IDLE.

Top module: `dbuf_dac_front`

## Requirements
- R1: Reset sets the code output to 14'h0000, which is mid-scale.
- R2: In parallel mode (mode_serial = 0) with ld_n held low, the code output takes the bus word, unchanged, once the strobes return high. The code is 14-bit two's complement with bit 13 as the MSB: 14'h1FFF is the most positive value and 14'h2000 the most negative.
- R3: While cs_n and wr_n are both low, the code output stays frozen, even with ld_n low.
- R4: While both strobes are low, the staging register follows the bus. The word present just before the first strobe rises is the one kept, and later bus changes are not taken.
- R5: A write with ld_n high leaves the code output unchanged. A later low level on ld_n moves the staged word to the output.
- R6: Whichever of cs_n and wr_n rises first ends the write. One strobe low on its own writes nothing.
- R7: In serial mode (mode_serial = 1), a frame starts when fsync goes low. sdin is sampled on each rising sclk edge, MSB first. The first two bits are ignored, and the last 14 bits are staged when fsync rises.
- R8: A frame with any bit count other than 16 is discarded, and the staged word is left unchanged.
- R9: The parallel strobes have no effect in serial mode, and the serial pins have no effect in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_serial | input | 1 | Static load-source select: 1 selects serial, 0 selects parallel |
| cs_n | input | 1 | Parallel select strobe, active low |
| wr_n | input | 1 | Parallel write strobe, active low |
| pdata | input | 14 | Parallel data word |
| sclk | input | 1 | Serial clock |
| fsync | input | 1 | Frame sync, low during a frame |
| sdin | input | 1 | Serial data |
| ld_n | input | 1 | Transfer strobe, active low |
| code_out | output | 14 | Output register contents |

## Verification
On every cycle, the assertions check three things:
- The two registers never change in the same cycle.
- The output register changes only after the latch-control machine opened it.
- The staging register changes in serial mode only after a serial commit, and a commit occurs only with a count of exactly 16 bits.

The bench scenarios cover the behaviours a single-cycle property cannot show:
- the value the staging register actually keeps when a strobe rises;
- automatic update with the transfer strobe held low;
- the don't-care leading bits and MSB-first order of a frame;
- discarding of short and long frames;
- the ignoring of the unselected interface, as seen at code_out.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CODE_W_DEF  = 14;
    localparam int FRAME_W_DEF = 16;

    typedef enum logic [1:0] {
        LC_IDLE,
        LC_IN_OPEN,
        LC_DAC_OPEN
    } lc_state_t;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_SHIFT,
        SR_COMMIT
    } sr_state_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_serial_rx.sv
module dacfe_serial_rx
    import dacfe_pkg::*;
#(
    parameter int CODE_W  = CODE_W_DEF,
    parameter int FRAME_W = FRAME_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sclk_s,
    input  logic              fsync_s,
    input  logic              sdin_s,
    output logic              commit,
    output logic [CODE_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    sr_state_t         state, state_nx;
    logic              sclk_d, fsync_d;
    logic              sclk_rise, fsync_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CODE_W-1:0] shreg;

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign fsync_rise = fsync_s & ~fsync_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            fsync_d <= 1'b1;
        end else begin
            sclk_d  <= sclk_s;
            fsync_d <= fsync_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SR_IDLE:   if (enable && !fsync_s) state_nx = SR_SHIFT;
            SR_SHIFT: begin
                if (!enable)         state_nx = SR_IDLE;
                else if (fsync_rise) state_nx = (bit_cnt == CNT_FULL) ? SR_COMMIT : SR_IDLE;
            end
            SR_COMMIT: state_nx = SR_IDLE;
            default:   state_nx = SR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit = (state == SR_COMMIT);
        word   = shreg;
    end

    // shift path and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                SR_IDLE: bit_cnt <= '0;
                SR_SHIFT: begin
                    if (sclk_rise && !fsync_s) begin
                        shreg <= {shreg[CODE_W-2:0], sdin_s};
                        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                SR_COMMIT: bit_cnt <= bit_cnt;
                default:   bit_cnt <= '0;
            endcase
        end
    end

    assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_COMMIT) |-> (bit_cnt == CNT_FULL))
        else $error("serial commit with wrong bit count");
endmodule

// File: rtl/dacfe_latch_ctrl.sv
module dacfe_latch_ctrl
    import dacfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic ld_req,
    output logic in_en,
    output logic dac_en
);
    lc_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LC_IDLE: begin
                if (in_req)      state_nx = LC_IN_OPEN;
                else if (ld_req) state_nx = LC_DAC_OPEN;
            end
            LC_IN_OPEN: begin
                if (!in_req) state_nx = ld_req ? LC_DAC_OPEN : LC_IDLE;
            end
            LC_DAC_OPEN: begin
                if (in_req)       state_nx = LC_IN_OPEN;
                else if (!ld_req) state_nx = LC_IDLE;
            end
            default: state_nx = LC_IDLE;
        endcase
    end

    always_comb begin
        in_en  = (state == LC_IN_OPEN);
        dac_en = (state == LC_DAC_OPEN);
    end

    assert_in_blocks_dac_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_req |=> !dac_en)
        else $error("output register opened during a write");
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
    import dacfe_pkg::*;
#(
    parameter int CODE_W      = CODE_W_DEF,
    parameter int FRAME_W     = FRAME_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_serial,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [CODE_W-1:0] pdata,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              sdin,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code_out
);
    localparam int CTL_W = 6;

    logic [CTL_W-1:0]  ctl_s;
    logic              cs_s, wr_s, ld_s, sclk_s, fsync_s, sdin_s;
    logic [CODE_W-1:0] pdata_s, pdata_a;
    logic              ser_commit;
    logic [CODE_W-1:0] ser_word;
    logic              in_req, ld_req, in_en, dac_en;
    logic [CODE_W-1:0] in_q, dac_q;

    dacfe_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(6'b111010)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, wr_n, ld_n, sclk, fsync, sdin}),
        .q(ctl_s)
    );
    assign {cs_s, wr_s, ld_s, sclk_s, fsync_s, sdin_s} = ctl_s;

    dacfe_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(pdata), .q(pdata_s)
    );

    // align the bus with the registered latch-control state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pdata_a <= '0;
        else        pdata_a <= pdata_s;
    end

    dacfe_serial_rx #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_srx (
        .clk(clk), .rst_n(rst_n), .enable(mode_serial),
        .sclk_s(sclk_s), .fsync_s(fsync_s), .sdin_s(sdin_s),
        .commit(ser_commit), .word(ser_word)
    );

    assign in_req = mode_serial ? ser_commit : (!cs_s && !wr_s);
    assign ld_req = !ld_s;

    dacfe_latch_ctrl u_lctl (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .ld_req(ld_req),
        .in_en(in_en), .dac_en(dac_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (in_en)  in_q  <= mode_serial ? ser_word : pdata_a;
            if (dac_en) dac_q <= in_q;
        end
    end

    assign code_out = dac_q;

    assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(dac_q) && !$stable(in_q)))
        else $error("both registers changed in one cycle");

    assert_dac_only_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_q) |-> $past(dac_en))
        else $error("output register changed while closed");

    assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial && $past(mode_serial) && $past(mode_serial, 2) && !$stable(in_q))
            |-> $past(ser_commit, 2))
        else $error("staging register changed in serial mode without a frame");
endmodule

// File: tb/dbuf_dac_front_tb_top.sv
module dbuf_dac_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_serial = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [13:0] pdata = '0;
    logic        sclk = 1'b0, fsync = 1'b1, sdin = 1'b0;
    logic [13:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbuf_dac_front dut_i (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial),
        .cs_n(cs_n), .wr_n(wr_n), .pdata(pdata),
        .sclk(sclk), .fsync(fsync), .sdin(sdin),
        .ld_n(ld_n), .code_out(code_out)
    );

    // {stimulus, expected}
    localparam logic [27:0] VEC [6] = '{
        {14'h1FFF, 14'h1FFF}, {14'h2000, 14'h2000}, {14'h0000, 14'h0000},
        {14'h0001, 14'h0001}, {14'h3FFF, 14'h3FFF}, {14'h2AAA, 14'h2AAA}
    };

    task automatic wait_cy(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code_out=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic par_write(input logic [13:0] d);
        pdata = d; cs_n = 1'b0; wr_n = 1'b0;
        wait_cy(8);
        cs_n = 1'b1; wr_n = 1'b1;
        wait_cy(8);
    endtask

    task automatic ld_pulse();
        ld_n = 1'b0; wait_cy(8);
        ld_n = 1'b1; wait_cy(8);
    endtask

    task automatic ser_frame(input logic [16:0] bits, input int n);
        fsync = 1'b0; wait_cy(6);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i]; wait_cy(4);
            sclk = 1'b1;    wait_cy(4);
            sclk = 1'b0;
        end
        wait_cy(4);
        fsync = 1'b1; wait_cy(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cy(4);
        rst_n = 1'b1;
        wait_cy(4);
        check("R1 reset mid-scale", code_out, 14'h0000);

        // R2: auto update with ld_n held low
        ld_n = 1'b0;
        wait_cy(8);
        for (int v = 0; v < 6; v++) begin
            par_write(VEC[v][27:14]);
            check("R2 parallel auto update", code_out, VEC[v][13:0]);
        end

        // R3 freeze while both strobes low, R4 transparency
        pdata = 14'h0123; cs_n = 1'b0; wr_n = 1'b0;
        wait_cy(10);
        check("R3 output frozen during write", code_out, 14'h2AAA);
        pdata = 14'h0456;
        wait_cy(10);
        check("R3 output frozen after bus change", code_out, 14'h2AAA);
        cs_n = 1'b1;
        wait_cy(10);
        check("R4 staging followed bus", code_out, 14'h0456);
        wr_n = 1'b1;
        wait_cy(4);

        // R5 write with ld_n high, R4 later bus change ignored
        ld_n = 1'b1;
        wait_cy(8);
        par_write(14'h1111);
        pdata = 14'h2222;
        wait_cy(8);
        check("R5 no update with ld_n high", code_out, 14'h0456);
        ld_pulse();
        check("R4 captured word transferred (R5)", code_out, 14'h1111);

        // R6 cs_n rises first, wr_n rises later
        pdata = 14'h0777; wr_n = 1'b0; wait_cy(4);
        cs_n = 1'b0; wait_cy(8);
        cs_n = 1'b1; wait_cy(8);
        pdata = 14'h0999; wait_cy(8);
        wr_n = 1'b1; wait_cy(8);
        ld_pulse();
        check("R6 first rising strobe ends write", code_out, 14'h0777);
        // R6 wr_n rises first
        pdata = 14'h0321; cs_n = 1'b0; wait_cy(4);
        wr_n = 1'b0; wait_cy(8);
        wr_n = 1'b1; wait_cy(8);
        pdata = 14'h0654; wait_cy(8);
        cs_n = 1'b1; wait_cy(8);
        ld_pulse();
        check("R6 wr_n rising ends write", code_out, 14'h0321);
        // R6 single strobe writes nothing
        pdata = 14'h0ABC; cs_n = 1'b0; wait_cy(10); cs_n = 1'b1; wait_cy(4);
        wr_n = 1'b0; wait_cy(10); wr_n = 1'b1; wait_cy(8);
        ld_pulse();
        check("R6 single strobe ignored", code_out, 14'h0321);

        // R9 serial pins ignored in parallel mode
        ser_frame({1'b0, 2'b00, 14'h3ACE}, 16);
        ld_pulse();
        check("R9 serial ignored in parallel mode", code_out, 14'h0321);

        // R7 serial frames
        mode_serial = 1'b1;
        wait_cy(8);
        ser_frame({1'b0, 2'b11, 14'h1234}, 16);
        ld_pulse();
        check("R7 serial frame loaded", code_out, 14'h1234);
        ser_frame({1'b0, 2'b10, 14'h2001}, 16);
        ld_pulse();
        check("R7 serial frame MSB first", code_out, 14'h2001);

        // R8 wrong lengths
        ser_frame({2'b00, 15'h1555}, 15);
        ld_pulse();
        check("R8 short frame discarded", code_out, 14'h2001);
        ser_frame(17'h0ABCD, 17);
        ld_pulse();
        check("R8 long frame discarded", code_out, 14'h2001);

        // R9 parallel strobes ignored in serial mode
        ld_n = 1'b0; wait_cy(8);
        par_write(14'h0F0F);
        check("R9 parallel ignored in serial mode", code_out, 14'h2001);
        ld_n = 1'b1; wait_cy(8);

        // R1 reset mid-run
        rst_n = 1'b0; wait_cy(4);
        check("R1 reset clears output", code_out, 14'h0000);
        rst_n = 1'b1; wait_cy(8);
        ld_pulse();
        check("R1 staging cleared by reset", code_out, 14'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule